// File: doc/BRIEF.md
# Framed Serial Configuration Port

This block is a serial slave that gives a host access to a 24-bit configuration word and to a data path behind it. The host brings an active-low frame strobe low, toggles a serial clock and moves one bit per clock, most significant bit first. There are two strobes, one for write frames and one for read frames. An address select line, sampled when the frame opens, picks the target. Low selects the configuration word. High selects the data path, and the current operating mode then steers the transfer to the conversion result, the zero-scale coefficient or the full-scale coefficient.

A write takes effect only when the frame closes after exactly 24 serial clocks. A shorter frame is dropped and leaves nothing changed. Clocks after the 24th are not shifted in. The fields of the configuration word come out as separate outputs. A coefficient write shows up as a one-cycle strobe that carries the new 24-bit value. All serial inputs are resynchronised into the system clock domain, and their edges are found there.

Top module: `cfg_serial_port`

## Requirements
- R1: After reset every configuration field output is zero, which puts the mode at 000 (normal). `coef_wr_o` and `sdo_o` are low.
- R2: A write frame opened with `sel_i` low that carries exactly 24 clocks loads the word into the configuration register. The field outputs follow bit positions from the MSB down: mode [23:21], gain [20:18], channel [17:16], word length [15], ro [14], bo [13], polarity [12], filter [11:0].
- R3: A write frame that ends before 24 clocks leaves the configuration register unchanged.
- R4: In a write frame with more than 24 clocks, only the first 24 bits are loaded. Later bits have no effect.
- R5: A read frame opened with `sel_i` low returns the 24-bit configuration word on `sdo_o`, MSB first. The first bit is valid once the frame opens, and each later bit follows a falling serial clock edge.
- R6: A read frame opened with `sel_i` high in modes 000 to 101 returns `conv_data_i`. With word length 1 the word has 24 bits. With word length 0 the frame carries `conv_data_i[23:8]` in its first 16 bits, and zeros after them.
- R7: A read frame opened with `sel_i` high returns `zs_coef_i` in mode 110 and `fs_coef_i` in mode 111. In both cases the word has 24 bits, whatever the word-length bit holds.
- R8: A write frame opened with `sel_i` high that carries 24 clocks in mode 110 or 111 raises `coef_wr_o` for one cycle. `coef_sel_o` is 0 for zero-scale (mode 110) or 1 for full-scale (mode 111), and `coef_data_o` carries the word. A short frame of this kind produces no strobe. In any other mode such a frame produces no strobe and leaves the configuration unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from host |
| wr_frame_n_i | input | 1 | Write frame strobe, active low |
| rd_frame_n_i | input | 1 | Read frame strobe, active low |
| sdi_i | input | 1 | Serial data in |
| sel_i | input | 1 | Target select: 0 configuration, 1 data path |
| sdo_o | output | 1 | Serial data out |
| conv_data_i | input | 24 | Conversion result to read |
| zs_coef_i | input | 24 | Zero-scale coefficient to read |
| fs_coef_i | input | 24 | Full-scale coefficient to read |
| coef_wr_o | output | 1 | One-cycle coefficient write strobe |
| coef_sel_o | output | 1 | 0 zero-scale, 1 full-scale |
| coef_data_o | output | 24 | Coefficient write value |
| mode_o | output | 3 | Operating mode field |
| gain_o | output | 3 | Gain field |
| chan_o | output | 2 | Channel field |
| wl_o | output | 1 | Word length bit |
| ro_o | output | 1 | RO bit |
| bo_o | output | 1 | BO bit |
| bu_o | output | 1 | Polarity bit |
| fs_o | output | 12 | Filter selection field |

## Verification
The hardest cases to reach are the ones where the word length and the commit rule depend on the mode already stored. To test a coefficient write, or a read that ignores word length, the bench must first commit a configuration word in mode 110 or 111, and only then run the data-path frame.

The bench therefore chains frames. Randomly chosen configuration words set up each mode, and each is followed by a data-path read. Directed sequences then do the following:
- run short and overlong frames;
- write coefficients in both coefficient modes;
- try a data-path write in normal mode, which must be ignored.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam int CFG_W   = 24;
  localparam int SHORT_W = 16;

  typedef struct packed {
    logic [2:0]  mode;
    logic [2:0]  gain;
    logic [1:0]  chan;
    logic        wl;
    logic        ro;
    logic        bo;
    logic        bu;
    logic [11:0] filt;
  } cfg_word_t;

  function automatic logic is_coef_mode(input logic [2:0] m);
    return m[2] & m[1];
  endfunction

  // word placed MSB-first into the transmit shifter at frame start
  function automatic logic [CFG_W-1:0] tx_word(
    input cfg_word_t cfg, input logic sel,
    input logic [CFG_W-1:0] conv, input logic [CFG_W-1:0] zs,
    input logic [CFG_W-1:0] fsc);
    logic [CFG_W-1:0] w;
    if (!sel) w = cfg;
    else if (is_coef_mode(cfg.mode)) w = cfg.mode[0] ? fsc : zs;
    else if (cfg.wl) w = conv;
    else w = {conv[CFG_W-1 -: SHORT_W], {(CFG_W-SHORT_W){1'b0}}};
    return w;
  endfunction
endpackage

// File: rtl/cfgp_sync.sv
module cfgp_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[g] <= RST_VAL;
        else if (g == 0) st[g] <= d;
        else st[g] <= st[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q = st[STAGES-1];
endmodule

// File: rtl/cfgp_rx.sv
module cfgp_rx
  import cfgp_pkg::*;
#(
  parameter int WORD_W = CFG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_open,
  input  logic              frame_close,
  input  logic              frame_act,
  input  logic              sclk_rise,
  input  logic              sdi,
  output logic [WORD_W-1:0] word_o,
  output logic              commit_o
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] shreg;
  logic              take_bit;

  assign take_bit = frame_act && sclk_rise && (cnt != FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      shreg    <= '0;
      commit_o <= 1'b0;
    end else begin
      commit_o <= frame_close && (cnt == FULL);
      if (frame_open || frame_close) cnt <= '0;
      else if (take_bit) begin
        cnt   <= cnt + 1'b1;
        shreg <= {shreg[WORD_W-2:0], sdi};
      end
    end
  end

  assign word_o = shreg;

  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL); // R4
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == FULL && !frame_open && !frame_close) |=> $stable(shreg)); // R4
  AST_COMMIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> cnt == '0); // R3
  AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> !commit_o); // R2
endmodule

// File: rtl/cfgp_tx.sv
module cfgp_tx
  import cfgp_pkg::*;
#(
  parameter int WORD_W = CFG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic              active,
  input  logic [WORD_W-1:0] load_word,
  output logic              sdo_o
);
  logic [WORD_W-1:0] txsh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) txsh <= '0;
    else if (load) txsh <= load_word;
    else if (shift) txsh <= {txsh[WORD_W-2:0], 1'b0};
  end

  assign sdo_o = active & txsh[WORD_W-1];

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !shift) |=> $stable(txsh)); // R5
  AST_TX_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> txsh == $past(load_word)); // R5
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
  import cfgp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_i,
  input  logic             wr_frame_n_i,
  input  logic             rd_frame_n_i,
  input  logic             sdi_i,
  input  logic             sel_i,
  output logic             sdo_o,
  input  logic [CFG_W-1:0] conv_data_i,
  input  logic [CFG_W-1:0] zs_coef_i,
  input  logic [CFG_W-1:0] fs_coef_i,
  output logic             coef_wr_o,
  output logic             coef_sel_o,
  output logic [CFG_W-1:0] coef_data_o,
  output logic [2:0]       mode_o,
  output logic [2:0]       gain_o,
  output logic [1:0]       chan_o,
  output logic             wl_o,
  output logic             ro_o,
  output logic             bo_o,
  output logic             bu_o,
  output logic [11:0]      fs_o
);
  localparam int NSIG = 5;
  localparam logic [NSIG-1:0] IDLE = 5'b01100;  // {sclk, wfn, rfn, sdi, sel}

  logic [NSIG-1:0] s_now, s_prev;
  logic s_sclk, s_wfn, s_rfn, s_sdi, s_sel;
  logic p_sclk, p_wfn, p_rfn;

  cfgp_sync #(.W(NSIG), .STAGES(SYNC_STAGES), .RST_VAL(IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({sclk_i, wr_frame_n_i, rd_frame_n_i, sdi_i, sel_i}),
    .q(s_now));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s_prev <= IDLE;
    else s_prev <= s_now;
  end

  assign {s_sclk, s_wfn, s_rfn, s_sdi, s_sel} = s_now;
  assign p_sclk = s_prev[4];
  assign p_wfn  = s_prev[3];
  assign p_rfn  = s_prev[2];

  // named events for the checks
  logic sclk_rise, sclk_fall, wr_open, wr_close, rd_open;
  assign sclk_rise = s_sclk & ~p_sclk;
  assign sclk_fall = ~s_sclk & p_sclk;
  assign wr_open   = ~s_wfn & p_wfn;
  assign wr_close  = s_wfn & ~p_wfn;
  assign rd_open   = ~s_rfn & p_rfn;

  cfg_word_t        cfg_q;
  logic             wr_sel;
  logic [CFG_W-1:0] rx_word;
  logic             rx_commit;
  logic             cfg_commit, coef_commit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_sel <= 1'b0;
    else if (wr_open) wr_sel <= s_sel;
  end

  cfgp_rx #(.WORD_W(CFG_W)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .frame_open(wr_open), .frame_close(wr_close), .frame_act(~s_wfn),
    .sclk_rise(sclk_rise), .sdi(s_sdi),
    .word_o(rx_word), .commit_o(rx_commit));

  assign cfg_commit  = rx_commit & ~wr_sel;
  assign coef_commit = rx_commit & wr_sel & is_coef_mode(cfg_q.mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q       <= '0;
      coef_wr_o   <= 1'b0;
      coef_sel_o  <= 1'b0;
      coef_data_o <= '0;
    end else begin
      if (cfg_commit) cfg_q <= rx_word;
      coef_wr_o <= coef_commit;
      if (coef_commit) begin
        coef_sel_o  <= cfg_q.mode[0];
        coef_data_o <= rx_word;
      end
    end
  end

  cfgp_tx #(.WORD_W(CFG_W)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .load(rd_open), .shift(sclk_fall & ~s_rfn), .active(~s_rfn),
    .load_word(tx_word(cfg_q, s_sel, conv_data_i, zs_coef_i, fs_coef_i)),
    .sdo_o(sdo_o));

  assign mode_o = cfg_q.mode;
  assign gain_o = cfg_q.gain;
  assign chan_o = cfg_q.chan;
  assign wl_o   = cfg_q.wl;
  assign ro_o   = cfg_q.ro;
  assign bo_o   = cfg_q.bo;
  assign bu_o   = cfg_q.bu;
  assign fs_o   = cfg_q.filt;

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_commit |=> $stable(cfg_q)); // R3
  AST_COEF_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    coef_wr_o |-> mode_o[2:1] == 2'b11); // R8
  AST_COEF_NO_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    coef_wr_o |-> $stable(cfg_q)); // R8
  AST_RESET_MODE: assert property (@(posedge clk)
    !rst_n |=> (mode_o == 3'b000 || rst_n)); // R1
endmodule

// File: tb/cfg_serial_port_tb_top.sv
`timescale 1ns/1ps
module cfg_serial_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, wfn = 1'b1, rfn = 1'b1, sdi = 1'b0, sel = 1'b0;
  logic sdo;
  logic [23:0] conv = '0, zs = '0, fsc = '0;
  logic coef_wr, coef_sel;
  logic [23:0] coef_data;
  logic [2:0] mode, gain;
  logic [1:0] chan;
  logic wl, ro, bo, bu;
  logic [11:0] filt;

  int checks = 0, failures = 0;
  int pulses = 0;
  logic last_sel;
  logic [23:0] last_data;
  logic [23:0] exp_cfg = '0;
  bit done = 0;

  always #4 clk = ~clk;

  cfg_serial_port dut_i (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .wr_frame_n_i(wfn),
    .rd_frame_n_i(rfn), .sdi_i(sdi), .sel_i(sel), .sdo_o(sdo),
    .conv_data_i(conv), .zs_coef_i(zs), .fs_coef_i(fsc),
    .coef_wr_o(coef_wr), .coef_sel_o(coef_sel), .coef_data_o(coef_data),
    .mode_o(mode), .gain_o(gain), .chan_o(chan), .wl_o(wl), .ro_o(ro),
    .bo_o(bo), .bu_o(bu), .fs_o(filt));

  always @(negedge clk) if (coef_wr) begin
    pulses++;
    last_sel = coef_sel;
    last_data = coef_data;
  end

  task automatic check(input string req, input logic [23:0] got, input logic [23:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_frame(input logic a, input logic [23:0] w, input int n);
    sel = a; idle(8);
    wfn = 1'b0; idle(8);
    for (int i = 0; i < n; i++) begin
      sdi = (i < 24) ? w[23-i] : 1'($urandom);
      idle(8); sclk = 1'b1; idle(8); sclk = 1'b0;
    end
    idle(8); wfn = 1'b1; idle(12);
  endtask

  task automatic read_frame(input logic a, output logic [23:0] r);
    r = '0;
    sel = a; idle(8);
    rfn = 1'b0; idle(8);
    for (int i = 0; i < 24; i++) begin
      r = {r[22:0], sdo};
      sclk = 1'b1; idle(8); sclk = 1'b0; idle(8);
    end
    rfn = 1'b1; idle(12);
  endtask

  function automatic logic [23:0] fields();
    return {mode, gain, chan, wl, ro, bo, bu, filt};
  endfunction

  function automatic logic [23:0] exp_high(input logic [23:0] c);
    case (c[23:21])
      3'b110: return zs;
      3'b111: return fsc;
      default: return c[15] ? conv : {conv[23:8], 8'h00};
    endcase
  endfunction

  initial begin
    logic [23:0] w, r;
    int p0;
    void'($urandom(32'h5EED_0713));
    idle(5); rst_n = 1'b1; idle(5);
    check("R1 fields", fields(), 24'h0);
    check("R1 mode", {21'h0, mode}, 24'h0);
    check("R1 sdo/strobe", {22'h0, sdo, coef_wr}, 24'h0);

    for (int k = 0; k < 20; k++) begin
      w = 24'($urandom);
      write_frame(1'b0, w, 24); exp_cfg = w;
      check("R2 fields", fields(), exp_cfg);
      check("R2 mode[23:21]", {21'h0, mode}, {21'h0, exp_cfg[23:21]});
      read_frame(1'b0, r);
      check("R5 cfg read", r, exp_cfg);
      conv = 24'($urandom); zs = 24'($urandom); fsc = 24'($urandom);
      read_frame(1'b1, r);
      if (exp_cfg[23:22] == 2'b11) check("R7 coef read", r, exp_high(exp_cfg));
      else check("R6 data read", r, exp_high(exp_cfg));
    end

    // R6 both word lengths, normal mode
    write_frame(1'b0, 24'h000000, 24); exp_cfg = 24'h000000;
    conv = 24'hA5C3_7E; read_frame(1'b1, r);
    check("R6 wl0 16-bit", r, 24'hA5C300);
    write_frame(1'b0, 24'h008000, 24); exp_cfg = 24'h008000;
    read_frame(1'b1, r);
    check("R6 wl1 24-bit", r, 24'hA5C37E);

    // R3 short frame
    write_frame(1'b0, 24'h123456, 10);
    check("R3 short frame", fields(), exp_cfg);
    write_frame(1'b0, 24'hFFFFFF, 23);
    check("R3 23 clocks", fields(), exp_cfg);

    // R4 overlong frame
    write_frame(1'b0, 24'h2B4D6F, 31); exp_cfg = 24'h2B4D6F;
    check("R4 extra clocks", fields(), exp_cfg);

    // R7 coef read ignores word length (wl=0 here)
    write_frame(1'b0, 24'hC00000, 24); exp_cfg = 24'hC00000;
    zs = 24'h13579B; read_frame(1'b1, r);
    check("R7 zs wl0", r, 24'h13579B);

    // R8 coefficient writes
    p0 = pulses;
    write_frame(1'b1, 24'h9ABCDE, 24);
    check("R8 zs pulse count", 24'(pulses - p0), 24'd1);
    check("R8 zs sel", {23'h0, last_sel}, 24'h0);
    check("R8 zs data", last_data, 24'h9ABCDE);
    check("R8 cfg unchanged", fields(), exp_cfg);
    p0 = pulses;
    write_frame(1'b1, 24'h111111, 12);
    check("R8 short coef no pulse", 24'(pulses - p0), 24'd0);
    write_frame(1'b0, 24'hE08000, 24); exp_cfg = 24'hE08000;
    fsc = 24'h0F0F0F; read_frame(1'b1, r);
    check("R7 fs read", r, 24'h0F0F0F);
    p0 = pulses;
    write_frame(1'b1, 24'h456789, 24);
    check("R8 fs pulse count", 24'(pulses - p0), 24'd1);
    check("R8 fs sel", {23'h0, last_sel}, 24'h1);
    check("R8 fs data", last_data, 24'h456789);
    write_frame(1'b0, 24'h000ABC, 24); exp_cfg = 24'h000ABC;
    p0 = pulses;
    write_frame(1'b1, 24'hFFFFFF, 24);
    check("R8 normal mode no pulse", 24'(pulses - p0), 24'd0);
    check("R8 normal mode cfg kept", fields(), exp_cfg);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog R1 got=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule